// File: doc/BRIEF.md
# Stream Frame Boundary Checker

This block sits on the input side of a processor that works on frames of a fixed number of samples, such as an N-point transform. It passes an AXI4-Stream flow through to a downstream port with no change and no added latency. While the stream passes, it counts accepted beats against a runtime frame length. Its own count, and never the incoming TLAST, decides where each frame ends.

Each accepted beat is compared with the internal frame boundary. A frame-end beat that arrives without TLAST produces a one-cycle pulse on one event wire. A beat with TLAST that is not a frame end produces a one-cycle pulse on a second event wire. Each event wire is a bare valid-only flag that never stalls the stream. The events do not latch, so a system can count them, route them to an interrupt input, or ignore them.

Top module: `frame_edge_check`

## Requirements
- R1: `m_data`, `m_last` and `m_valid` equal `s_data`, `s_last` and `s_valid` in the same cycle, and `s_ready` equals `m_ready` in the same cycle, whether or not an event is active.
- R2: A beat is accepted when `s_valid` and `m_ready` are both 1. A frame ends on the L-th accepted beat after reset or after the previous frame end. TLAST never restarts this count: with L=4, a TLAST on the 2nd beat does not move the frame end away from the 4th beat.
- R3: After the clock edge that accepts a frame-end beat with `s_last`=0, `evt_missing_last` is 1 for exactly the next cycle.
- R4: After the clock edge that accepts a beat with `s_last`=1 that is not a frame end, `evt_extra_last` is 1 for exactly the next cycle.
- R5: A cycle that has no accepted beat (either `s_valid`=0 or `m_ready`=0) produces no event and does not advance the beat count.
- R6: The two events are never 1 together. They do not latch: each one is 1 only in a cycle that directly follows a qualifying acceptance, and back-to-back mismatches give back-to-back pulses.
- R7: `cfg_frame_len` is sampled at reset and on each accepted frame-end beat. A change in the middle of a frame takes effect only from the next frame.
- R8: A `cfg_frame_len` value of 0 behaves as a frame length of 1.
- R9: While `rst_n` is 0 at a rising clock edge, the beat count returns to the start of a frame and both events are 0 in the following cycle.
- R10: With L=32 and one unbroken 2048-beat packet that has TLAST only on its last beat, exactly 63 missing-TLAST pulses and no unexpected-TLAST pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_frame_len | input | LEN_W | Frame length in beats (0 means 1) |
| s_data | input | DATA_W | Upstream sample data |
| s_last | input | 1 | Upstream packet-end marker |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Ready toward upstream |
| m_data | output | DATA_W | Forwarded sample data |
| m_last | output | 1 | Forwarded packet-end marker |
| m_valid | output | 1 | Forwarded beat valid |
| m_ready | input | 1 | Ready from downstream |
| evt_missing_last | output | 1 | Pulse: frame ended without TLAST |
| evt_extra_last | output | 1 | Pulse: TLAST away from a frame end |

## Verification
On every cycle the assertions check that the two events are never high together. They check that any event follows an accepted beat, and that each event type matches the TLAST value of that beat. Only the bench's scenarios can show where frame ends fall. These include sweeps over small frame lengths with stalls in between, the case where TLAST does not resynchronise the count, the deferred pickup of a length change, the zero-length case, and reset in the middle of a frame. The bench also checks the exact event total for a long grouped packet and the pass-through of the data path.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef struct packed {
        logic missing;
        logic extra;
    } fbc_evt_t;

    localparam fbc_evt_t FBC_EVT_NONE = '{missing: 1'b0, extra: 1'b0};

    function automatic fbc_evt_t fbc_classify(input logic accept,
                                              input logic frame_end,
                                              input logic beat_last);
        fbc_evt_t r;
        r.missing = accept &  frame_end & ~beat_last;
        r.extra   = accept & ~frame_end &  beat_last;
        return r;
    endfunction

endpackage

// File: rtl/fbc_frame_counter.sv
module fbc_frame_counter #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             frame_end
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] last_idx;

    always_comb begin
        len_eff   = (st_q.len == '0) ? LEN_W'(1) : st_q.len;
        last_idx  = len_eff - LEN_W'(1);
        frame_end = (st_q.cnt == last_idx);
        st_d      = st_q;
        if (accept) begin
            if (frame_end) begin
                st_d.cnt = '0;
                st_d.len = cfg_len;
            end else begin
                st_d.cnt = st_q.cnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.len <= cfg_len;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fbc_event_gen.sv
module fbc_event_gen
    import fbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic frame_end,
    input  logic beat_last,
    output logic evt_missing,
    output logic evt_extra
);
    fbc_evt_t ev_d, ev_q;

    always_comb begin
        ev_d = fbc_classify(accept, frame_end, beat_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= FBC_EVT_NONE;
        else        ev_q <= ev_d;
    end

    assign evt_missing = ev_q.missing;
    assign evt_extra   = ev_q.extra;
endmodule

// File: rtl/frame_edge_check.sv
module frame_edge_check #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_frame_len,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              evt_missing_last,
    output logic              evt_extra_last
);
    logic accept;
    logic frame_end;

    assign m_data  = s_data;
    assign m_last  = s_last;
    assign m_valid = s_valid;
    assign s_ready = m_ready;
    assign accept  = s_valid & m_ready;

    fbc_frame_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cfg_len   (cfg_frame_len),
        .frame_end (frame_end)
    );

    fbc_event_gen u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .frame_end   (frame_end),
        .beat_last   (s_last),
        .evt_missing (evt_missing_last),
        .evt_extra   (evt_extra_last)
    );
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker (
    input logic clk,
    input logic rst_n,
    input logic s_valid,
    input logic s_last,
    input logic m_ready,
    input logic evt_missing_last,
    input logic evt_extra_last
);
    assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_missing_last && evt_extra_last));

    assert_event_needs_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_missing_last || evt_extra_last) |-> $past(s_valid && m_ready));

    assert_missing_had_no_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_missing_last |-> !$past(s_last));

    assert_extra_had_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_extra_last |-> $past(s_last));
endmodule

bind frame_edge_check fbc_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .s_valid          (s_valid),
    .s_last           (s_last),
    .m_ready          (m_ready),
    .evt_missing_last (evt_missing_last),
    .evt_extra_last   (evt_extra_last)
);

// File: tb/sim_frame_edge_check.sv
module sim_frame_edge_check;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int LW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] cfg_frame_len = '0;
    logic [DW-1:0] s_data = '0;
    logic s_last = 1'b0, s_valid = 1'b0, m_ready = 1'b0;
    logic s_ready, m_last, m_valid, evt_missing_last, evt_extra_last;
    logic [DW-1:0] m_data;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_edge_check #(.DATA_W(DW), .LEN_W(LW)) u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_beat(input logic v, input logic r, input logic l,
                           output logic em, output logic ee);
        s_valid = v; m_ready = r; s_last = l; s_data = s_data + 1'b1;
        @(posedge clk); #1;
        em = evt_missing_last; ee = evt_extra_last;
    endtask

    task automatic apply_reset(input int len);
        rst_n = 1'b0; cfg_frame_len = LW'(len); s_valid = 0; m_ready = 0; s_last = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R9 missing after reset", int'(evt_missing_last), 0);
        check("R9 extra after reset", int'(evt_extra_last), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic em, ee;
        int cm, ce;
        // R1 pass-through, exercised while held in reset
        for (int p = 0; p < 8; p++) begin
            s_valid = p[0]; m_ready = p[1]; s_last = p[2];
            s_data = DW'(16'hA5C3 ^ (p * 16'h1111));
            #1;
            check("R1 m_data", int'(m_data), int'(s_data));
            check("R1 m_last", int'(m_last), int'(s_last));
            check("R1 m_valid", int'(m_valid), int'(s_valid));
            check("R1 s_ready", int'(s_ready), int'(m_ready));
        end

        // R2..R6 sweep over small lengths with stalls
        for (int len = 1; len <= 6; len++) begin
            apply_reset(len);
            for (int k = 0; k < 3*len + 2; k++) begin
                bit lst, fe;
                lst = (k % 3 == 2);
                fe  = ((k + 1) % len == 0);
                if (k % 4 == 1) begin
                    do_beat(1, 0, 1, em, ee);
                    check("R5 no event ready low", int'({em, ee}), 0);
                    do_beat(0, 1, 1, em, ee);
                    check("R5 no event valid low", int'({em, ee}), 0);
                end
                do_beat(1, 1, lst, em, ee);
                check($sformatf("R3 missing L=%0d k=%0d", len, k), int'(em), int'(fe && !lst));
                check($sformatf("R4 extra L=%0d k=%0d", len, k), int'(ee), int'(!fe && lst));
                check("R6 exclusive", int'(em && ee), 0);
            end
            do_beat(0, 1, 0, em, ee);
            check("R6 no latch", int'({em, ee}), 0);
        end

        // R2 TLAST does not resynchronise the count
        apply_reset(4);
        do_beat(1, 1, 0, em, ee);
        do_beat(1, 1, 1, em, ee);
        check("R2 early last flagged", int'(ee), 1);
        do_beat(1, 1, 0, em, ee);
        do_beat(1, 1, 1, em, ee);
        check("R2 end still at 4th beat", int'({em, ee}), 0);

        // R7 mid-frame length change
        apply_reset(4);
        for (int k = 0; k < 8; k++) begin
            if (k == 2) cfg_frame_len = LW'(2);
            do_beat(1, 1, 0, em, ee);
            check($sformatf("R7 missing k=%0d", k), int'(em), int'(k == 3 || k == 5 || k == 7));
        end

        // R8 zero length behaves as one
        apply_reset(0);
        for (int k = 0; k < 4; k++) begin
            do_beat(1, 1, k[0], em, ee);
            check("R8 missing", int'(em), int'(!k[0]));
            check("R8 extra", int'(ee), 0);
        end

        // R9 reset in the middle of a frame
        apply_reset(4);
        do_beat(1, 1, 0, em, ee);
        do_beat(1, 1, 0, em, ee);
        apply_reset(4);
        for (int k = 0; k < 4; k++) begin
            do_beat(1, 1, k == 3, em, ee);
            check("R9 count restarted", int'({em, ee}), 0);
        end

        // R10 grouped packet
        apply_reset(32);
        cm = 0; ce = 0;
        for (int k = 0; k < 2048; k++) begin
            do_beat(1, 1, k == 2047, em, ee);
            cm += int'(em); ce += int'(ee);
        end
        check("R10 missing count", cm, 63);
        check("R10 extra count", ce, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule